// File: doc/BRIEF.md
# Event-Triggered Single-Transfer Data Mover

This block is one channel of an event-driven copy engine. Each request pulse from a peripheral makes the channel copy one data item, a byte or a 16-bit word, from a source address to a destination address. It does this with one read and then one write on a shared memory port, taking one bus slot for each. After each copy the source pointer, the destination pointer, or both can step forward. An 8-bit transfer counter counts down. The copy that brings it to zero also raises the channel's interrupt. This lets a processor handle a block of up to 255 silent copies and then one normal service call.

Software sets up the channel through a small write-only register port. The registers are the two 16-bit pointers, the count and a control word. A typical use is memory refresh: the source steps through consecutive rows and the destination stays fixed on a dummy location, so the data read is thrown away. A free-running mode leaves the counter untouched. With fixed pointers the copies then go on forever with no interrupt. Requests that arrive while a copy is in flight are counted and served one after another. None is lost.

The memory port uses a valid/ready handshake. The channel holds `mem_req` high together with a stable address, direction, size and write data until it samples `mem_gnt` high on a rising edge. The memory may stall the port for any number of cycles. Read data must be valid on `mem_rdata` in the cycle the read is granted.

Top module: `evt_copy_channel`

## Requirements
- R1: After reset, `busy`, `mem_req` and `irq` are low. The pointers, count and control word are zero, so a first event produces an interrupt and no memory access.
- R2: Each serviced event makes exactly one read at the source pointer (`mem_we`=0). The write at the destination pointer (`mem_we`=1) is requested in the cycle right after the read grant.
- R3: Control bit 0 selects the width (1 = word, 0 = byte) and drives `mem_size`. A word copy writes the 16 bits that were read. A byte copy writes `{8'h00, rdata[7:0]}`.
- R4: After each copy, a pointer whose increment bit is set steps by 2 for words or 1 for bytes, modulo 2^16. Control bit 1 is the source increment and bit 2 the destination increment. A pointer without its bit set stays where it is.
- R5: In counted mode each copy decrements the count. The copy that reaches zero raises `irq` for one cycle, in the cycle after its write grant. No other copy raises `irq`.
- R6: An event taken while the count is zero (counted mode) does no memory access. It raises `irq` two cycles after the event cycle.
- R7: With control bit 3 set (free-running), copies never raise `irq` and leave the count unchanged.
- R8: Events that arrive while the channel is busy are queued, up to 2^PEND_W-1 of them. Each one is later served as a copy, so the number of writes equals the number of events.
- R9: While `mem_req` is high and `mem_gnt` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R10: Register select values are 0 = source pointer, 1 = destination pointer, 2 = count (low 8 bits of the write data), 3 = control. `busy` is high in every cycle in which `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| evt | input | 1 | Event request, one copy per high cycle |
| mem_req | output | 1 | Memory access valid |
| mem_gnt | input | 1 | Memory access accepted (ready) |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 1 | 1 = word, 0 = byte |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the read grant cycle |
| busy | output | 1 | A copy is between its read and its write completion |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The assertions check every cycle that a stalled request holds its address, direction and data. They also check that a granted read is followed at once by a write, that every interrupt comes either from a completed copy or from an event taken at zero count, that the free-running mode never interrupts, and that the request queue neither overflows nor is drained while empty. The bench scenarios are the only place that shows the data itself. They cover pointer stepping and wrap-around for both widths, byte masking, the exact copy that empties the counter, the zero-count interrupt, the count left untouched by free-running copies, and that no queued event is lost when events arrive in bursts under random grant stalls.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eng_state_t;

  typedef struct packed {
    logic free_run;
    logic dst_inc;
    logic src_inc;
    logic word;
  } xfer_ctrl_t;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_DST  = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;
endpackage

// File: rtl/ecc_cfg_regs.sv
module ecc_cfg_regs
  import ecc_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             done,
  output logic [AW-1:0]    src_ptr,
  output logic [AW-1:0]    dst_ptr,
  output logic [CNT_W-1:0] count,
  output xfer_ctrl_t       ctrl
);
  logic [AW-1:0] step;
  assign step = ctrl.word ? AW'(2) : AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ptr <= '0;
      dst_ptr <= '0;
      count   <= '0;
      ctrl    <= '0;
    end else begin
      if (done && ctrl.src_inc)           src_ptr <= src_ptr + step;
      else if (cfg_we && cfg_sel == SEL_SRC) src_ptr <= cfg_wdata;

      if (done && ctrl.dst_inc)           dst_ptr <= dst_ptr + step;
      else if (cfg_we && cfg_sel == SEL_DST) dst_ptr <= cfg_wdata;

      if (done && !ctrl.free_run && count != '0) count <= count - CNT_W'(1);
      else if (cfg_we && cfg_sel == SEL_CNT)     count <= cfg_wdata[CNT_W-1:0];

      if (cfg_we && cfg_sel == SEL_CTRL) ctrl <= xfer_ctrl_t'(cfg_wdata[3:0]);
    end
  end
endmodule

// File: rtl/ecc_pend_ctr.sv
module ecc_pend_ctr #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic take,
  output logic pend_nz
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  logic [PEND_W-1:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else begin
      unique case ({evt, take})
        2'b10:   if (pend != PEND_MAX) pend <= pend + PEND_W'(1);
        2'b01:   pend <= pend - PEND_W'(1);
        default: pend <= pend;
      endcase
    end
  end

  assign pend_nz = (pend != '0);

  // R8
  take_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend != '0);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == PEND_MAX && evt) |-> take);
endmodule

// File: rtl/ecc_xfer_engine.sv
module ecc_xfer_engine
  import ecc_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_nz,
  input  logic [CNT_W-1:0] count,
  input  xfer_ctrl_t       ctrl,
  input  logic [AW-1:0]    src_ptr,
  input  logic [AW-1:0]    dst_ptr,
  input  logic             mem_gnt,
  input  logic [DW-1:0]    mem_rdata,
  output logic             take,
  output logic             done,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             busy,
  output logic             irq
);
  eng_state_t st, nxt;
  logic [DW-1:0] data_q;
  logic irq_set, irq_q;

  always_comb begin
    nxt      = st;
    take     = 1'b0;
    done     = 1'b0;
    irq_set  = 1'b0;
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = src_ptr;
    unique case (st)
      ST_IDLE: if (pend_nz) begin
        take = 1'b1;
        if (ctrl.free_run || count != '0) nxt = ST_READ;
        else irq_set = 1'b1;
      end
      ST_READ: begin
        mem_req = 1'b1;
        if (mem_gnt) nxt = ST_WRITE;
      end
      ST_WRITE: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_ptr;
        if (mem_gnt) begin
          done = 1'b1;
          nxt  = ST_IDLE;
          if (!ctrl.free_run && count == CNT_W'(1)) irq_set = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      data_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      st    <= nxt;
      irq_q <= irq_set;
      if (st == ST_READ && mem_gnt)
        data_q <= ctrl.word ? mem_rdata : {{(DW-8){1'b0}}, mem_rdata[7:0]};
    end
  end

  assign mem_wdata = data_q;
  assign busy      = (st != ST_IDLE);
  assign irq       = irq_q;

  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && !mem_we) |=> (mem_req && mem_we));
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(mem_req && mem_we && mem_gnt) || $past(pend_nz && !busy)));
endmodule

// File: rtl/evt_copy_channel.sv
module evt_copy_channel
  import ecc_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int CNT_W  = 8,
  parameter int PEND_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          evt,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_we,
  output logic          mem_size,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          irq
);
  logic [AW-1:0]    src_ptr, dst_ptr;
  logic [CNT_W-1:0] count;
  xfer_ctrl_t       ctrl;
  logic             pend_nz, take, done;

  ecc_cfg_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .done(done), .src_ptr(src_ptr),
    .dst_ptr(dst_ptr), .count(count), .ctrl(ctrl)
  );

  ecc_pend_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt), .take(take), .pend_nz(pend_nz)
  );

  ecc_xfer_engine #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .pend_nz(pend_nz), .count(count),
    .ctrl(ctrl), .src_ptr(src_ptr), .dst_ptr(dst_ptr), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .take(take), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy), .irq(irq)
  );

  assign mem_size = ctrl.word;

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata)));
  // R7
  free_run_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.free_run && done) |=> !irq);
  // R10
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

// File: tb/evt_copy_channel_test.sv
module evt_copy_channel_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, evt = 1'b0, mem_gnt = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic mem_req, mem_we, mem_size, busy, irq;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0, fails = 0;
  int fired = 0, wrs = 0, irq_seen = 0, irq_exp = 0;
  logic [15:0] exp_src, exp_dst, exp_data;
  int exp_cnt = 0;
  logic [3:0] exp_ctrl = '0;
  bit exp_irq_next = 0, stall_prev = 0;
  logic [15:0] prev_addr, prev_wd;
  logic prev_we;

  always #4 clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0] ^ 8'h3C, a[15:8] ^ 8'hC5};
  endfunction
  function automatic logic [15:0] shape(input logic [15:0] d, input bit word);
    return word ? d : {8'h00, d[7:0]};
  endfunction
  function automatic logic [15:0] stepf(input bit word);
    return word ? 16'd2 : 16'd1;
  endfunction

  assign mem_rdata = memf(mem_addr);

  evt_copy_channel uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .evt(evt), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic drv();
    @(posedge clk); #1;
  endtask

  // memory stall pattern
  initial forever begin
    @(posedge clk); #1;
    mem_gnt = ($urandom % 3) != 0;
  end

  // port monitor and reference model
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (exp_irq_next) chk(irq == 1'b1, "R5 irq after final copy", irq, 1);
      exp_irq_next = 0;
      if (irq) irq_seen++;
      if (mem_req) chk(busy == 1'b1, "R10 busy during access", busy, 1);
      if (stall_prev)
        chk(mem_req && mem_addr == prev_addr && mem_we == prev_we &&
            mem_wdata == prev_wd, "R9 hold under stall", mem_addr, prev_addr);
      stall_prev = mem_req && !mem_gnt;
      prev_addr = mem_addr; prev_we = mem_we; prev_wd = mem_wdata;
      if (mem_req && mem_gnt) begin
        if (!mem_we) begin
          chk(mem_addr == exp_src, "R2 read address", mem_addr, exp_src);
          chk(mem_size == exp_ctrl[0], "R3 size", mem_size, exp_ctrl[0]);
          exp_data = shape(memf(exp_src), exp_ctrl[0]);
        end else begin
          chk(mem_addr == exp_dst, "R2 write address", mem_addr, exp_dst);
          chk(mem_wdata == exp_data, "R3 write data", mem_wdata, exp_data);
          wrs++;
          if (exp_ctrl[1]) exp_src = exp_src + stepf(exp_ctrl[0]);
          if (exp_ctrl[2]) exp_dst = exp_dst + stepf(exp_ctrl[0]);
          if (!exp_ctrl[3] && exp_cnt > 0) begin
            exp_cnt--;
            if (exp_cnt == 0) begin exp_irq_next = 1; irq_exp++; end
          end
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
    drv(); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    drv(); cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] d, input int c,
                       input logic [3:0] ct);
    cfg_write(2'd0, s); cfg_write(2'd1, d);
    cfg_write(2'd2, 16'(c)); cfg_write(2'd3, {12'h000, ct});
    exp_src = s; exp_dst = d; exp_cnt = c; exp_ctrl = ct;
  endtask

  task automatic fire(input int n);
    for (int i = 0; i < n; i++) begin
      while (fired - wrs >= 8) drv();
      drv(); evt = 1'b1; fired++;
      drv(); evt = 1'b0;
      repeat ($urandom % 4) drv();
    end
  endtask

  task automatic drain(input string tag);
    while (fired != wrs || busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(irq_seen == irq_exp, {tag, " irq total"}, irq_seen, irq_exp);
    chk(wrs == fired, "R8 writes equal events", wrs, fired);
  endtask

  task automatic zero_evt(input string tag);
    int w0 = wrs;
    drv(); evt = 1'b1;
    drv(); evt = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(irq == 1'b1, {tag, " zero-count irq"}, irq, 1);
    chk(mem_req == 1'b0, {tag, " no access at zero count"}, mem_req, 0);
    irq_exp++;
    repeat (4) @(negedge clk);
    chk(wrs == w0, {tag, " no copy at zero count"}, wrs, w0);
    chk(irq_seen == irq_exp, {tag, " irq total"}, irq_seen, irq_exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mem_req == 0 && irq == 0, "R1 reset outputs",
        {busy, mem_req, irq}, 0);
    zero_evt("R1");

    // byte copies, source wraps at top of the 16-bit range, counter empties
    setup(16'hFFFF, 16'h1000, 3, 4'b0010); fire(3); drain("R4 R5 byte wrap");
    chk(exp_src == 16'h0002, "R4 src wrap", exp_src, 16'h0002);
    zero_evt("R6");

    // word copies, both pointers step by two, source wraps
    setup(16'hFFFE, 16'h2000, 2, 4'b0111); fire(2); drain("R4 R5 word");

    // refresh-like walk: source steps, destination fixed, no interrupt yet
    setup(16'h4000, 16'h00F0, 255, 4'b0011); fire(20); drain("R4 refresh");

    // free running with fixed pointers leaves count at 1
    setup(16'h1234, 16'h5678, 1, 4'b1000); fire(10); drain("R7 free run");
    cfg_write(2'd3, 16'h0000); exp_ctrl = 4'b0000;
    fire(1); drain("R7 count untouched");

    // burst of events under random stalls
    setup(16'h0100, 16'h0800, 12, 4'b0101);
    for (int i = 0; i < 12; i++) begin
      drv(); evt = 1'b1; fired++;
    end
    drv(); evt = 1'b0;
    drain("R8 burst");

    // constrained random rounds
    for (int r = 0; r < 30; r++) begin
      logic [3:0] ct = 4'($urandom);
      int c = 1 + ($urandom % 255);
      int n = 1 + ($urandom % 12);
      if ($urandom % 3 == 0) c = 1 + ($urandom % 6);
      if (!ct[3] && n > c) n = c;
      setup(16'($urandom), 16'($urandom), c, ct);
      fire(n);
      drain("R5 random");
    end
    finish_run();
  end
endmodule